// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This block watches a processor's internal bus and requests a debug break when a programmed condition matches. Two channels, A and B, each hold a base address, an address mask and a condition word. A set mask bit removes that address bit from the comparison, so one channel can cover a small aligned range. The condition word picks the cycle type (instruction fetch or operand access), can narrow the match to one operand size or one direction, and can require the current address-space identifier (ASID) to equal the channel's own 8-bit ASID value. Channel B can in addition compare the bus data under a data mask.

The channels run either independently, where a hit on either one breaks, or in sequence, where a channel A hit only arms the block and the break comes on a later channel B hit. A fetch break is requested either before the fetched instruction executes, in the cycle of the fetch, or after it, held until the core's completion strobe. Each channel keeps a sticky hit flag in the control register. All registers are written through a simple address/data/write-enable port and can be read back combinationally.

Top module: `brk_match_unit`

## Requirements
- R1: After reset every register and flag reads zero, both channels are disabled and `brkReq` stays low for any bus activity.
- R2: A channel compares `busAddr` with its base only on bits whose mask bit is 0; base 0x8010 with mask 0x6 hits 0x8010, 0x8012, 0x8014 and 0x8016 but not 0x8011 or 0x8018. Offsets: A base 0, A mask 1, B base 4, B mask 5.
- R3: With condition bit 8 set, channel B also requires `busData` to equal its data value (offset 8) on every bit whose data mask bit (offset 9) is 0; channel A ignores bit 8.
- R4: Condition bit 0 enables a channel; bit 1 selects instruction fetch (0) or operand access (1); bits 5:4 select any size (00) or byte/word/long (01/10/11, against `busSize` 00/01/10); on operand accesses bit 2 enables a direction check against bit 3 (1 = write). Condition offsets: A 2, B 6.
- R5: With condition bit 6 set, a channel hits only when `busAsid` equals its ASID register (A offset 3, B offset 7).
- R6: A fetch break with condition bit 7 clear raises `brkReq` in the cycle of the matching bus cycle with `brkAfter` low; an operand break raises `brkReq` in that cycle with `brkAfter` high.
- R7: A fetch break with condition bit 7 set is held pending and raised for exactly one cycle, with `brkAfter` high, in the first later cycle in which `instrDone` is high.
- R8: With control bit 0 clear (control offset 10), a hit on either channel alone raises a break.
- R9: With control bit 0 set, a channel A hit raises no break and arms the block; a channel B hit breaks only if armed in an earlier cycle, and the break clears the armed state.
- R10: Any write to the control register clears the armed state.
- R11: Control bits 1 and 2 are sticky hit flags of channels A and B; writing 0 to a flag clears it, writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | RAW (4) | Register offset for write and read |
| regWdata | input | RW (32) | Register write data |
| regRdata | output | RW (32) | Read data of the register at `regAddr` |
| busValid | input | 1 | A bus cycle is present |
| busFetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| busWrite | input | 1 | 1 = operand write, 0 = read |
| busSize | input | 2 | 00 byte, 01 word, 10 long |
| busAddr | input | AW (32) | Bus address |
| busData | input | DW (32) | Bus data |
| busAsid | input | IW (8) | Current address-space identifier |
| instrDone | input | 1 | Completion strobe of the oldest fetched instruction |
| brkReq | output | 1 | Break request |
| brkAfter | output | 1 | 1 = break after execution/access, 0 = before execution |

## Verification
Before-execution and operand break requests are combinational, due in the same cycle as the bus cycle, so the bench drives each bus cycle just after a falling edge and samples two nanoseconds later, before the next rising edge. An after-execution request is due only in a later cycle carrying `instrDone`, and the bench checks that it is absent in the match cycle and in an idle cycle, present in the first completion cycle and absent in the next. Register writes, flags and the armed state take effect at the rising edge that ends the write or hit cycle, so every read-back and every dependent bus cycle is issued in a following cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;

  // Register offsets; channel c uses c*CH_STRIDE + OFF_*
  localparam int CH_STRIDE = 4;
  localparam int OFF_ADDR  = 0;
  localparam int OFF_MASK  = 1;
  localparam int OFF_COND  = 2;
  localparam int OFF_ASID  = 3;
  localparam int OFF_DATA  = 8;
  localparam int OFF_DMASK = 9;
  localparam int OFF_CTRL  = 10;

  // Condition word bit positions
  localparam int C_EN    = 0;
  localparam int C_OPER  = 1;
  localparam int C_DIREN = 2;
  localparam int C_DIR   = 3;
  localparam int C_SZLO  = 4;
  localparam int C_SZHI  = 5;
  localparam int C_ASID  = 6;
  localparam int C_LATE  = 7;
  localparam int C_DATA  = 8;
  localparam int CW      = 9;

  // Datapath to control strobes
  typedef struct packed {
    logic hitA;
    logic hitB;
    logic lateA;
    logic lateB;
    logic isFetch;
    logic seqMode;
    logic ctrlWr;
  } brk_strobe_t;

endpackage

// File: rtl/brk_chan_match.sv
module brk_chan_match
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8
) (
  input  logic          busValid,
  input  logic          busFetch,
  input  logic          busWrite,
  input  logic [1:0]    busSize,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  input  logic [IW-1:0] busAsid,
  input  logic [CW-1:0] cond,
  input  logic [AW-1:0] baseAddr,
  input  logic [AW-1:0] addrMask,
  input  logic [IW-1:0] asidVal,
  input  logic [DW-1:0] dataVal,
  input  logic [DW-1:0] dataMask,
  output logic          hit,
  output logic          late
);

  logic addrOk, typeOk, dirOk, sizeOk, asidOk, dataOk;
  logic [1:0] sizeSel;

  assign sizeSel = cond[C_SZHI:C_SZLO];
  assign addrOk  = ((busAddr ^ baseAddr) & ~addrMask) == '0;
  assign typeOk  = cond[C_OPER] ? !busFetch : busFetch;
  assign dirOk   = !cond[C_OPER] || !cond[C_DIREN] || (busWrite == cond[C_DIR]);
  assign sizeOk  = (sizeSel == 2'b00) || (sizeSel == 2'(busSize + 2'd1));
  assign asidOk  = !cond[C_ASID] || (busAsid == asidVal);
  assign dataOk  = !cond[C_DATA] || (((busData ^ dataVal) & ~dataMask) == '0);

  assign hit  = busValid && cond[C_EN] && addrOk && typeOk && dirOk
              && sizeOk && asidOk && dataOk;
  assign late = busFetch && cond[C_LATE];

endmodule

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IW  = 8,
  parameter int RAW = 4,
  parameter int RW  = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWe,
  input  logic [RAW-1:0] regAddr,
  input  logic [RW-1:0]  regWdata,
  output logic [RW-1:0]  regRdata,
  input  logic           busValid,
  input  logic           busFetch,
  input  logic           busWrite,
  input  logic [1:0]     busSize,
  input  logic [AW-1:0]  busAddr,
  input  logic [DW-1:0]  busData,
  input  logic [IW-1:0]  busAsid,
  output brk_strobe_t    strb
);

  localparam int NCH = 2;

  logic [AW-1:0] addrR [NCH];
  logic [AW-1:0] maskR [NCH];
  logic [CW-1:0] condR [NCH];
  logic [IW-1:0] asidR [NCH];
  logic [DW-1:0] dataR, dmaskR;
  logic          seqR;
  logic [NCH-1:0] flagR, hitV, lateV;
  logic          ctrlWr;
  int            offs;

  assign offs   = int'(regAddr);
  assign ctrlWr = regWe && (offs == OFF_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        addrR[c] <= '0;
        maskR[c] <= '0;
        condR[c] <= '0;
        asidR[c] <= '0;
      end
      dataR  <= '0;
      dmaskR <= '0;
      seqR   <= 1'b0;
      flagR  <= '0;
    end else begin
      if (regWe) begin
        for (int c = 0; c < NCH; c++) begin
          if (offs == c*CH_STRIDE + OFF_ADDR) addrR[c] <= AW'(regWdata);
          if (offs == c*CH_STRIDE + OFF_MASK) maskR[c] <= AW'(regWdata);
          if (offs == c*CH_STRIDE + OFF_ASID) asidR[c] <= IW'(regWdata);
          if (offs == c*CH_STRIDE + OFF_COND) begin
            // only the last channel owns a data compare
            condR[c] <= regWdata[CW-1:0] & ((c == NCH-1) ? {CW{1'b1}} : {1'b0, {(CW-1){1'b1}}});
          end
        end
        if (offs == OFF_DATA)  dataR  <= DW'(regWdata);
        if (offs == OFF_DMASK) dmaskR <= DW'(regWdata);
        if (ctrlWr)            seqR   <= regWdata[0];
      end
      for (int c = 0; c < NCH; c++) begin
        flagR[c] <= hitV[c] | (flagR[c] & !(ctrlWr && !regWdata[1+c]));
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : gChan
    localparam bit HAS_DATA = (c == NCH-1);
    brk_chan_match #(.AW(AW), .DW(DW), .IW(IW)) matchU (
      .busValid (busValid),
      .busFetch (busFetch),
      .busWrite (busWrite),
      .busSize  (busSize),
      .busAddr  (busAddr),
      .busData  (busData),
      .busAsid  (busAsid),
      .cond     (condR[c]),
      .baseAddr (addrR[c]),
      .addrMask (maskR[c]),
      .asidVal  (asidR[c]),
      .dataVal  (HAS_DATA ? dataR : '0),
      .dataMask (HAS_DATA ? dmaskR : '0),
      .hit      (hitV[c]),
      .late     (lateV[c])
    );
  end

  always_comb begin
    regRdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (offs == c*CH_STRIDE + OFF_ADDR) regRdata = RW'(addrR[c]);
      if (offs == c*CH_STRIDE + OFF_MASK) regRdata = RW'(maskR[c]);
      if (offs == c*CH_STRIDE + OFF_COND) regRdata = RW'(condR[c]);
      if (offs == c*CH_STRIDE + OFF_ASID) regRdata = RW'(asidR[c]);
    end
    if (offs == OFF_DATA)  regRdata = RW'(dataR);
    if (offs == OFF_DMASK) regRdata = RW'(dmaskR);
    if (offs == OFF_CTRL)  regRdata = RW'({flagR, seqR});
  end

  assign strb.hitA    = hitV[0];
  assign strb.hitB    = hitV[1];
  assign strb.lateA   = lateV[0];
  assign strb.lateB   = lateV[1];
  assign strb.isFetch = busFetch;
  assign strb.seqMode = seqR;
  assign strb.ctrlWr  = ctrlWr;

endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrDone,
  input  brk_strobe_t strb,
  output logic        brkReq,
  output logic        brkAfter,
  output logic        armedQ,
  output logic        pendingQ
);

  logic effA, effB, immNow, lateSet, releaseNow;

  assign effA       = strb.hitA && !strb.seqMode;
  assign effB       = strb.hitB && (!strb.seqMode || armedQ);
  assign immNow     = (effA && !strb.lateA) || (effB && !strb.lateB);
  assign lateSet    = (effA && strb.lateA) || (effB && strb.lateB);
  assign releaseNow = pendingQ && instrDone && !immNow;

  assign brkReq   = immNow || releaseNow;
  assign brkAfter = immNow ? !strb.isFetch : releaseNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ   <= 1'b0;
      pendingQ <= 1'b0;
    end else begin
      pendingQ <= lateSet || (pendingQ && !releaseNow);
      if (strb.ctrlWr)                     armedQ <= 1'b0;
      else if (effB && strb.seqMode)       armedQ <= 1'b0;
      else if (strb.hitA && strb.seqMode)  armedQ <= 1'b1;
    end
  end

endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
  import brk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IW  = 8,
  parameter int RAW = 4,
  parameter int RW  = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWe,
  input  logic [RAW-1:0] regAddr,
  input  logic [RW-1:0]  regWdata,
  output logic [RW-1:0]  regRdata,
  input  logic           busValid,
  input  logic           busFetch,
  input  logic           busWrite,
  input  logic [1:0]     busSize,
  input  logic [AW-1:0]  busAddr,
  input  logic [DW-1:0]  busData,
  input  logic [IW-1:0]  busAsid,
  input  logic           instrDone,
  output logic           brkReq,
  output logic           brkAfter
);

  brk_strobe_t strb;
  logic armedQ, pendingQ;

  brk_datapath #(.AW(AW), .DW(DW), .IW(IW), .RAW(RAW), .RW(RW)) dpath_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busValid(busValid),
    .busFetch(busFetch), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busData(busData), .busAsid(busAsid), .strb(strb)
  );

  brk_control ctrl_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .strb(strb),
    .brkReq(brkReq), .brkAfter(brkAfter), .armedQ(armedQ), .pendingQ(pendingQ)
  );

endmodule

// File: rtl/brk_match_unit_chk.sv
module brk_match_unit_chk (
  input logic clk,
  input logic rstN,
  input logic busValid,
  input logic busFetch,
  input logic instrDone,
  input logic brkReq,
  input logic brkAfter,
  input logic armedQ,
  input logic pendingQ,
  input logic seqMode,
  input logic ctrlWr
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busValid && !pendingQ) |-> !brkReq);  // R1

  AST_LATE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && brkAfter && !(busValid && !busFetch)) |-> (instrDone && pendingQ));  // R7

  AST_LATE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && instrDone && brkReq && brkAfter && !busValid) |=> !pendingQ);  // R7

  AST_SEQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (seqMode && brkReq && !pendingQ) |-> armedQ);  // R9

  AST_CTRL_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !armedQ);  // R10

endmodule

bind brk_match_unit brk_match_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busFetch(busFetch),
  .instrDone(instrDone), .brkReq(brkReq), .brkAfter(brkAfter),
  .armedQ(armedQ), .pendingQ(pendingQ), .seqMode(strb.seqMode),
  .ctrlWr(strb.ctrlWr)
);

// File: tb/brk_match_unit_tb_top.sv
module brk_match_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busValid = 1'b0, busFetch = 1'b0, busWrite = 1'b0;
  logic [1:0]  busSize = '0;
  logic [31:0] busAddr = '0, busData = '0;
  logic [7:0]  busAsid = '0;
  logic        instrDone = 1'b0;
  logic        brkReq, brkAfter;

  int nChecks = 0;
  int nFail = 0;
  logic sReq, sAft;
  logic [31:0] rv;

  always #5 clk = ~clk;

  brk_match_unit dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busValid(busValid),
    .busFetch(busFetch), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busData(busData), .busAsid(busAsid),
    .instrDone(instrDone), .brkReq(brkReq), .brkAfter(brkAfter)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    regAddr = a;
    #1 rv = regRdata;
  endtask

  task automatic bus(input logic f, input logic w, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] d,
                     input logic [7:0] id, input logic done);
    busValid = 1'b1; busFetch = f; busWrite = w; busSize = sz;
    busAddr = a; busData = d; busAsid = id; instrDone = done;
    #2 sReq = brkReq; sAft = brkAfter;
    @(negedge clk);
    busValid = 1'b0; instrDone = 1'b0;
  endtask

  task automatic idle(input logic done);
    busValid = 1'b0; instrDone = done;
    #2 sReq = brkReq; sAft = brkAfter;
    @(negedge clk);
    instrDone = 1'b0;
  endtask

  task automatic t_reset;
    rd(4'd10); chk("R1 ctrl after reset", rv, 0);
    rd(4'd2);  chk("R1 condA after reset", rv, 0);
    bus(1, 0, 2'b01, 32'h0, 32'h0, 8'h0, 0);
    chk("R1 no break at reset", {31'b0, sReq}, 0);
  endtask

  task automatic t_mask;
    wr(4'd0, 32'h8010); wr(4'd1, 32'h6); wr(4'd2, 32'h001);
    bus(1, 0, 2'b01, 32'h8016, 0, 0, 0);
    chk("R2 hit 0x8016", {30'b0, sReq, sAft}, 32'h2);  // R6 before: after=0
    bus(1, 0, 2'b01, 32'h8012, 0, 0, 0);
    chk("R2 hit 0x8012", {31'b0, sReq}, 1);
    bus(1, 0, 2'b01, 32'h8018, 0, 0, 0);
    chk("R2 miss 0x8018", {31'b0, sReq}, 0);
    bus(1, 0, 2'b01, 32'h8011, 0, 0, 0);
    chk("R2 miss 0x8011", {31'b0, sReq}, 0);
  endtask

  task automatic t_flags;
    wr(4'd10, 32'h0);
    bus(1, 0, 2'b01, 32'h8010, 0, 0, 0);
    rd(4'd10); chk("R11 flagA set", rv, 32'h2);
    wr(4'd10, 32'h2);
    rd(4'd10); chk("R11 write one keeps", rv, 32'h2);
    wr(4'd10, 32'h0);
    rd(4'd10); chk("R11 write zero clears", rv, 32'h0);
  endtask

  task automatic t_late;
    wr(4'd0, 32'h404); wr(4'd1, 32'h0); wr(4'd2, 32'h081);
    bus(1, 0, 2'b01, 32'h404, 0, 0, 0);
    chk("R7 not in match cycle", {31'b0, sReq}, 0);
    idle(0);
    chk("R7 not before done", {31'b0, sReq}, 0);
    idle(1);
    chk("R7 on done", {30'b0, sReq, sAft}, 32'h3);
    idle(1);
    chk("R7 single pulse", {31'b0, sReq}, 0);
  endtask

  task automatic t_qual;
    wr(4'd0, 32'h50); wr(4'd1, 32'h0); wr(4'd2, 32'h023);
    bus(0, 0, 2'b01, 32'h50, 0, 0, 0);
    chk("R6 operand word read", {30'b0, sReq, sAft}, 32'h3);
    bus(0, 0, 2'b10, 32'h50, 0, 0, 0);
    chk("R4 long size miss", {31'b0, sReq}, 0);
    bus(1, 0, 2'b01, 32'h50, 0, 0, 0);
    chk("R4 fetch type miss", {31'b0, sReq}, 0);
    wr(4'd2, 32'h02F);
    bus(0, 0, 2'b01, 32'h50, 0, 0, 0);
    chk("R4 read vs write-only miss", {31'b0, sReq}, 0);
    bus(0, 1, 2'b01, 32'h50, 0, 0, 0);
    chk("R4 write hit", {31'b0, sReq}, 1);
  endtask

  task automatic t_asid;
    wr(4'd0, 32'h60); wr(4'd3, 32'h80); wr(4'd2, 32'h041);
    bus(1, 0, 2'b01, 32'h60, 0, 8'h80, 0);
    chk("R5 asid match", {31'b0, sReq}, 1);
    bus(1, 0, 2'b01, 32'h60, 0, 8'h70, 0);
    chk("R5 asid mismatch", {31'b0, sReq}, 0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_data;
    wr(4'd4, 32'h40); wr(4'd5, 32'h0); wr(4'd8, 32'h1234); wr(4'd9, 32'hF);
    wr(4'd6, 32'h103);
    bus(0, 0, 2'b10, 32'h40, 32'h1235, 0, 0);
    chk("R3 data masked match", {30'b0, sReq, sAft}, 32'h3);
    bus(0, 0, 2'b10, 32'h40, 32'h1335, 0, 0);
    chk("R3 data mismatch", {31'b0, sReq}, 0);
    wr(4'd2, 32'h103);
    rd(4'd2); chk("R3 channel A drops data bit", rv, 32'h003);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_seq;
    wr(4'd0, 32'h100); wr(4'd1, 32'h0); wr(4'd2, 32'h001);
    wr(4'd4, 32'h200); wr(4'd5, 32'h0); wr(4'd6, 32'h001);
    wr(4'd10, 32'h0);
    bus(1, 0, 2'b01, 32'h200, 0, 0, 0);
    chk("R8 independent B alone", {31'b0, sReq}, 1);
    wr(4'd10, 32'h1);
    bus(1, 0, 2'b01, 32'h200, 0, 0, 0);
    chk("R9 B unarmed no break", {31'b0, sReq}, 0);
    bus(1, 0, 2'b01, 32'h100, 0, 0, 0);
    chk("R9 A only arms", {31'b0, sReq}, 0);
    bus(1, 0, 2'b01, 32'h200, 0, 0, 0);
    chk("R9 armed B breaks", {30'b0, sReq, sAft}, 32'h2);
    bus(1, 0, 2'b01, 32'h200, 0, 0, 0);
    chk("R9 arm cleared by break", {31'b0, sReq}, 0);
    bus(1, 0, 2'b01, 32'h100, 0, 0, 0);
    wr(4'd10, 32'h1);
    bus(1, 0, 2'b01, 32'h200, 0, 0, 0);
    chk("R10 ctrl write disarms", {31'b0, sReq}, 0);
    wr(4'd10, 32'h0);
  endtask

  initial begin
    #1_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_flags();
    t_late();
    t_qual();
    t_asid();
    t_data();
    t_seq();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule